// File: doc/BRIEF.md
# One-Time Commit User Word

This block holds one 32-bit user configuration word whose contents can be made permanent once. The top bit is a "not yet committed" flag that the hardware manages. The low 31 bits carry user data. Before a commit, software writes the data bits over a simple select/write bus into a shadow register, and every read returns the flag together with the shadow value. A separate commit request copies the shadow into a persistent store and clears the flag. From then on, the word is frozen, and any further commit request is refused with a one-cycle error pulse.

The shadow, the store and the flag stand in for non-volatile cells. Only the power-on reset clears them, and it returns them to all ones. The system reset restarts only the commit sequencer. A small state machine runs the commit. Its states are IDLE (waiting), PROG (the copy cycle, during which bus writes are closed), DONE (a one-cycle success pulse) and ERR (a one-cycle refusal pulse). Its transitions are:

- IDLE to PROG on a request while the flag is 1.
- IDLE to ERR on a request while the flag is 0.
- PROG to DONE unconditionally, ignoring any request.
- DONE or ERR to ERR on a request.
- DONE or ERR to IDLE otherwise.

Top module: `otp_user_word`

## Requirements
- R1: After power-on reset, `bus_rdata` reads 0xFFFFFFFF: flag bit 31 is 1 and data bits 30:0 are all ones.
- R2: While uncommitted and idle, a cycle with `bus_sel` and `bus_wr` high loads `bus_wdata[30:0]` into bits 30:0. Bit 31 of the written word is ignored, so the flag stays 1.
- R3: A `commit_req` sampled in IDLE while the flag is 1 raises `commit_done` for exactly one cycle, two clock edges after the request edge. From that cycle on, bit 31 reads 0 and bits 30:0 keep the data held at the commit.
- R4: A `commit_req` sampled while the flag is 0 raises `commit_err` for one cycle after that edge. It does not raise `commit_done` and does not change `bus_rdata`.
- R5: After a commit, bus writes have no effect on `bus_rdata`.
- R6: Holding `sys_rst_n` low leaves `bus_rdata` unchanged, whether the word is committed or not.
- R7: A power-on reset returns `bus_rdata` to 0xFFFFFFFF, including after a commit. This is the only way the flag returns to 1.
- R8: A bus write on the same edge that accepts a commit is part of the committed data. A bus write on the next edge (the PROG cycle) is dropped.
- R9: `commit_done` and `commit_err` are never high together. A request sampled in the PROG cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears all storage to ones |
| sys_rst_n | input | 1 | System reset, active low; restarts the sequencer only |
| bus_sel | input | 1 | Bus access to the word |
| bus_wr | input | 1 | Write qualifier for `bus_sel` |
| bus_wdata | input | 32 | Write data; bits 30:0 used |
| bus_rdata | output | 32 | Read word: flag in bit 31, data in 30:0 |
| commit_req | input | 1 | Request to make the word permanent |
| commit_done | output | 1 | One-cycle pulse on a successful commit |
| commit_err | output | 1 | One-cycle pulse on a refused commit |

## Verification
A bus write and an accepted commit request can land on the same edge. A write can also arrive on the edge that follows, while the copy is in progress. The bench drives a write together with the request edge and expects that data in the frozen word. It then drives a second write one edge later and expects the frozen word not to change. A request held over two edges provokes the ignored request in PROG, and the check is that only `commit_done` pulses.

// File: rtl/otpw_pkg.sv
package otpw_pkg;
    localparam int DATA_W = 31;
    localparam int WORD_W = DATA_W + 1;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PROG = 2'd1,
        S_DONE = 2'd2,
        S_ERR  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/otpw_shadow.sv
module otpw_shadow #(
    parameter int W = 31
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q <= '1;
        end else if (we) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/otpw_store.sv
module otpw_store #(
    parameter int W = 31
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         unwritten,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q         <= '1;
            unwritten <= 1'b1;
        end else if (load) begin
            q         <= din;
            unwritten <= 1'b0;
        end
    end
endmodule

// File: rtl/otpw_seq.sv
module otpw_seq
    import otpw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       unwritten,
    output logic       load,
    output logic       wr_open,
    output logic       done,
    output logic       err,
    output seq_state_t state
);
    seq_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (req) begin
                    nxt = unwritten ? S_PROG : S_ERR;
                end
            end
            S_PROG: nxt = S_DONE;
            S_DONE: nxt = req ? S_ERR : S_IDLE;
            S_ERR:  nxt = req ? S_ERR : S_IDLE;
        endcase
    end

    always_comb begin
        load    = 1'b0;
        wr_open = 1'b0;
        done    = 1'b0;
        err     = 1'b0;
        unique case (state)
            S_IDLE: wr_open = 1'b1;
            S_PROG: load    = 1'b1;
            S_DONE: done    = 1'b1;
            S_ERR:  err     = 1'b1;
        endcase
    end
endmodule

// File: rtl/otp_user_word.sv
module otp_user_word
    import otpw_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              commit_req,
    output logic              commit_done,
    output logic              commit_err
);
    logic              seq_rst_n;
    logic              load;
    logic              wr_open;
    logic              unwritten;
    logic              shadow_we;
    logic [DATA_W-1:0] shadow_q;
    logic [DATA_W-1:0] store_q;
    seq_state_t        state;

    assign seq_rst_n = por_n & sys_rst_n;
    assign shadow_we = bus_sel & bus_wr & wr_open & unwritten;

    otpw_seq u_seq (
        .clk       (clk),
        .rst_n     (seq_rst_n),
        .req       (commit_req),
        .unwritten (unwritten),
        .load      (load),
        .wr_open   (wr_open),
        .done      (commit_done),
        .err       (commit_err),
        .state     (state)
    );

    otpw_shadow #(.W(DATA_W)) u_shadow (
        .clk   (clk),
        .por_n (por_n),
        .we    (shadow_we),
        .wdata (bus_wdata[DATA_W-1:0]),
        .q     (shadow_q)
    );

    otpw_store #(.W(DATA_W)) u_store (
        .clk       (clk),
        .por_n     (por_n),
        .load      (load),
        .din       (shadow_q),
        .unwritten (unwritten),
        .q         (store_q)
    );

    assign bus_rdata = {unwritten, (unwritten ? shadow_q : store_q)};
endmodule

// File: rtl/otpw_checker.sv
module otpw_checker
    import otpw_pkg::*;
(
    input logic              clk,
    input logic              por_n,
    input logic              sys_rst_n,
    input logic              commit_req,
    input logic              commit_done,
    input logic              commit_err,
    input logic [WORD_W-1:0] bus_rdata
);
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        !(commit_done && commit_err)); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        commit_done |=> !commit_done); // R3
    AST_DONE_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
        commit_done |-> !bus_rdata[WORD_W-1]); // R3
    AST_ERR_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!por_n)
        commit_err |-> !bus_rdata[WORD_W-1]); // R4
    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
        !bus_rdata[WORD_W-1] |=> $stable(bus_rdata)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        !bus_rdata[WORD_W-1] |=> !bus_rdata[WORD_W-1]); // R7
endmodule

bind otp_user_word otpw_checker i_chk (.*);

// File: tb/test_otp_user_word.sv
module test_otp_user_word;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        commit_req = 1'b0;
    logic        commit_done;
    logic        commit_err;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_word;

    always #4 clk = ~clk;

    otp_user_word i_otp_user_word (.*);

    function automatic logic [31:0] model_write(logic [31:0] cur, logic sel, logic wr, logic [31:0] d);
        if (cur[31] && sel && wr) return {1'b1, d[30:0]};
        return cur;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0001));
        #20;
        por_n = 1'b1;
        sys_rst_n = 1'b1;
        @(negedge clk);
        chk("R1 por value", bus_rdata, 32'hFFFF_FFFF);
        chk("R1 no pulses", {30'd0, commit_done, commit_err}, 32'd0);
        exp_word = 32'hFFFF_FFFF;

        // R2 directed: bit 31 written 0 is ignored
        bus_sel = 1; bus_wr = 1; bus_wdata = 32'h1234_5678;
        tick();
        bus_sel = 0; bus_wr = 0;
        exp_word = 32'h9234_5678;
        chk("R2 flag kept", bus_rdata, exp_word);

        // R2 random writes
        for (int i = 0; i < 300; i++) begin
            logic s, w;
            logic [31:0] d;
            s = 1'($urandom); w = 1'($urandom); d = $urandom;
            bus_sel = s; bus_wr = w; bus_wdata = d;
            tick();
            exp_word = model_write(exp_word, s, w, d);
            chk("R2 random write", bus_rdata, exp_word);
        end
        bus_sel = 0; bus_wr = 0;

        // R6 uncommitted
        sys_rst_n = 0; tick(); tick();
        chk("R6 sys reset uncommitted", bus_rdata, exp_word);
        sys_rst_n = 1; tick();

        // R8/R9/R3: write with request edge, request held into PROG, write in PROG
        commit_req = 1; bus_sel = 1; bus_wr = 1; bus_wdata = 32'h0ABC_DEF0;
        tick();
        exp_word = {1'b1, 31'h0ABC_DEF0};
        chk("R3 no early done", {30'd0, commit_done, commit_err}, 32'd0);
        bus_wdata = 32'h7777_1111;
        tick();
        commit_req = 0; bus_sel = 0; bus_wr = 0;
        chk("R3 done pulse", {30'd0, commit_done, commit_err}, 32'd2);
        exp_word = {1'b0, 31'h0ABC_DEF0};
        chk("R8 committed data", bus_rdata, exp_word);
        tick();
        chk("R9 one done no err", {30'd0, commit_done, commit_err}, 32'd0);

        // R4 directed second commit
        commit_req = 1; tick(); commit_req = 0;
        chk("R4 err pulse", {30'd0, commit_done, commit_err}, 32'd1);
        chk("R4 data kept", bus_rdata, exp_word);
        tick();
        chk("R4 err one cycle", {30'd0, commit_done, commit_err}, 32'd0);

        // R5/R4 random after commit
        for (int i = 0; i < 300; i++) begin
            logic r;
            r = ($urandom % 5) == 0;
            bus_sel = 1'($urandom); bus_wr = 1'($urandom); bus_wdata = $urandom;
            commit_req = r;
            tick();
            chk("R5 frozen", bus_rdata, exp_word);
            chk("R4 err follows req", {30'd0, commit_done, commit_err}, {30'd0, 1'b0, r});
        end
        bus_sel = 0; bus_wr = 0; commit_req = 0;
        tick();

        // R6 committed
        sys_rst_n = 0; tick();
        chk("R6 sys reset committed", bus_rdata, exp_word);
        sys_rst_n = 1; tick();

        // R7 power-on reset
        por_n = 0; #2;
        chk("R7 por restores", bus_rdata, 32'hFFFF_FFFF);
        @(negedge clk); por_n = 1; tick();
        chk("R7 flag back", bus_rdata, 32'hFFFF_FFFF);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule